// File: doc/BRIEF.md
# DMA Page Translation Table

This block keeps a table of 64-bit translation entries, one for each fixed-size page of a device DMA window. Each entry holds the system page address in its upper bits and a two-bit access code in bits [1:0]. A lookup port accepts a DMA address and, one clock later, returns the page-aligned DMA address, the translated page address, the in-page offset mask and the access code. Addresses beyond the programmed window produce a result that grants no access. They do not raise an error.

Software-side agents use a register port to write or read a single entry. That port computes the index relative to a programmable bus offset. Accesses outside the window are refused with an error flag and do not change the table. Every accepted write emits a one-cycle invalidate notice so that translation caches further down can update. The window is set up through enable and disable requests, which carry the page shift, the bus offset and the entry count. The entries sit in a dual-port RAM of parameterized depth. A per-entry valid vector makes reset and re-enable read back as all-zero tables.

Top module: `dpt_xlate_table`

## Requirements
- R1: After reset every entry reads as zero: register reads return 0 and lookups return access code 0. After reset the window is disabled, and lk_valid, reg_ack and inv_valid are low.
- R2: lk_valid is high in the cycle after a cycle with lk_req high, and low in the cycle after a cycle with lk_req low.
- R3: lk_perm carries bits [1:0] of the entry: 0 = no access, 1 = read only, 2 = write only, 3 = read and write.
- R4: An in-range lookup uses index = lk_addr >> page_shift with no bus offset. It returns lk_iova = lk_addr with the low page_shift bits cleared, lk_xlat = entry with the low page_shift bits cleared, and lk_mask = 2^page_shift − 1.
- R5: A lookup whose index is at or above the entry count returns lk_perm 0, lk_iova 0, lk_xlat 0 and lk_mask all ones. This includes every lookup while the window is disabled.
- R6: A register access uses index = ((reg_addr with the low page_shift bits cleared) − bus_offset) >> page_shift, computed modulo 2^AW. reg_ack rises one cycle after reg_req. A read returns the full 64-bit entry on reg_rdata in that cycle.
- R7: A register access with an index at or above the entry count sets reg_err with reg_rdata 0. It leaves the table unchanged and raises no invalidate.
- R8: An accepted write pulses inv_valid for one cycle, together with reg_ack. The pulse carries inv_iova = ((aligned reg_addr − bus_offset) with the low page_shift bits cleared), inv_xlat = written entry with the low page_shift bits cleared, and inv_perm = written bits [1:0].
- R9: When a lookup and an accepted write hit the same index in the same cycle, the lookup result reflects the newly written entry.
- R10: An enable request is ignored while the entry count is nonzero. A disable request sets the bus offset, the page shift and the entry count to zero. When both requests arrive in the same cycle, the disable wins.
- R11: An accepted enable starts from an all-zero table, even for entries written before an earlier disable. A requested count above DEPTH is clamped to DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Enable request: opens the window using the three cfg values |
| cfg_disable | input | 1 | Disable request: closes the window |
| cfg_page_shift | input | SHW | log2 of the page size for an enable |
| cfg_bus_offset | input | AW | Window base for register accesses, for an enable |
| cfg_entries | input | CNT_W | Entry count for an enable |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | AW | DMA address to translate |
| lk_valid | output | 1 | Lookup result strobe |
| lk_iova | output | AW | Page-aligned DMA address |
| lk_xlat | output | EW | Page-aligned translated address |
| lk_mask | output | AW | In-page offset mask |
| lk_perm | output | 2 | Access code |
| reg_req | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | AW | Bus address of the entry's page |
| reg_wdata | input | EW | Entry value to write |
| reg_ack | output | 1 | Register access completion |
| reg_err | output | 1 | Index out of range, access refused |
| reg_rdata | output | EW | Entry value for reads |
| inv_valid | output | 1 | Invalidate notice strobe |
| inv_iova | output | AW | Page DMA address of the updated entry |
| inv_xlat | output | EW | New translated page address |
| inv_perm | output | 2 | New access code |

## Verification
A corrupt entry, a stale valid bit or a wrong index computation shows up at lk_xlat and lk_perm on the very next lookup of that page. It also appears at reg_rdata one cycle after a read. A wrong configuration register shows up in the offset mask and the in-range decision of the next lookup: a page just beyond the window must give an all-ones mask, and the last page inside it must not. A missed write-to-lookup bypass appears only in the single cycle where both hit one index, so the bench issues them together. Missing clears on reset or re-enable are caught by reading back pages that held data before.

// File: rtl/dpt_pkg.sv
package dpt_pkg;
  localparam int PERM_W = 2;

  typedef enum logic [PERM_W-1:0] {
    PERM_NONE = 2'd0,
    PERM_RD   = 2'd1,
    PERM_WR   = 2'd2,
    PERM_RW   = 2'd3
  } perm_e;
endpackage

// File: rtl/dpt_cfg.sv
module dpt_cfg #(
  parameter int AW    = 48,
  parameter int SHW   = 6,
  parameter int DEPTH = 256,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_req,
  input  logic             dis_req,
  input  logic [SHW-1:0]   req_shift,
  input  logic [AW-1:0]    req_off,
  input  logic [CNT_W-1:0] req_count,
  output logic [SHW-1:0]   shift,
  output logic [AW-1:0]    off,
  output logic [CNT_W-1:0] count,
  output logic             wipe
);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(DEPTH);

  logic             en_ok;
  logic [CNT_W-1:0] cnt_clamped;

  assign en_ok       = en_req && !dis_req && (count == '0);
  assign wipe        = dis_req || en_ok;
  assign cnt_clamped = (req_count > MAX_CNT) ? MAX_CNT : req_count;

  always_ff @(posedge clk) begin
    if (rst || dis_req) begin
      shift <= '0;
      off   <= '0;
      count <= '0;
    end else if (en_ok) begin
      shift <= req_shift;
      off   <= req_off;
      count <= cnt_clamped;
    end
  end
endmodule

// File: rtl/dpt_ram.sv
module dpt_ram #(
  parameter int DW    = 64,
  parameter int DEPTH = 256,
  parameter int IW    = 8
) (
  input  logic          clk,
  input  logic          a_en,
  input  logic [IW-1:0] a_addr,
  output logic [DW-1:0] a_q,
  input  logic          b_en,
  input  logic          b_we,
  input  logic [IW-1:0] b_addr,
  input  logic [DW-1:0] b_wd,
  output logic [DW-1:0] b_q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_en) a_q <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    if (b_en) begin
      if (b_we) mem[b_addr] <= b_wd;
      b_q <= mem[b_addr];
    end
  end
endmodule

// File: rtl/dpt_vbits.sv
module dpt_vbits #(
  parameter int DEPTH = 256,
  parameter int IW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wipe,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic [IW-1:0] a_idx,
  output logic          a_q,
  input  logic [IW-1:0] b_idx,
  output logic          b_q
);
  logic [DEPTH-1:0] vb;

  always_ff @(posedge clk) begin
    if (rst || wipe) vb <= '0;
    else if (set_en) vb[set_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= vb[a_idx];
      b_q <= vb[b_idx];
    end
  end
endmodule

// File: rtl/dpt_xlate_table.sv
module dpt_xlate_table #(
  parameter int AW    = 48,
  parameter int EW    = 64,
  parameter int SHW   = 6,
  parameter int DEPTH = 256,
  parameter int IW    = $clog2(DEPTH),
  parameter int CNT_W = IW + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_enable,
  input  logic                     cfg_disable,
  input  logic [SHW-1:0]           cfg_page_shift,
  input  logic [AW-1:0]            cfg_bus_offset,
  input  logic [CNT_W-1:0]         cfg_entries,
  input  logic                     lk_req,
  input  logic [AW-1:0]            lk_addr,
  output logic                     lk_valid,
  output logic [AW-1:0]            lk_iova,
  output logic [EW-1:0]            lk_xlat,
  output logic [AW-1:0]            lk_mask,
  output logic [dpt_pkg::PERM_W-1:0] lk_perm,
  input  logic                     reg_req,
  input  logic                     reg_we,
  input  logic [AW-1:0]            reg_addr,
  input  logic [EW-1:0]            reg_wdata,
  output logic                     reg_ack,
  output logic                     reg_err,
  output logic [EW-1:0]            reg_rdata,
  output logic                     inv_valid,
  output logic [AW-1:0]            inv_iova,
  output logic [EW-1:0]            inv_xlat,
  output logic [dpt_pkg::PERM_W-1:0] inv_perm
);
  import dpt_pkg::*;

  // configuration state
  logic [SHW-1:0]   cur_shift;
  logic [AW-1:0]    cur_off;
  logic [CNT_W-1:0] cur_count;
  logic             wipe;

  dpt_cfg #(.AW(AW), .SHW(SHW), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst(rst),
    .en_req(cfg_enable), .dis_req(cfg_disable),
    .req_shift(cfg_page_shift), .req_off(cfg_bus_offset), .req_count(cfg_entries),
    .shift(cur_shift), .off(cur_off), .count(cur_count), .wipe(wipe)
  );

  // page masks at the current shift
  logic [AW-1:0] pmask_a;
  logic [EW-1:0] pmask_e;
  assign pmask_a = ~((AW'(1) << cur_shift) - AW'(1));
  assign pmask_e = ~((EW'(1) << cur_shift) - EW'(1));

  // index decode for both ports
  logic [AW-1:0] lk_idx_full, reg_base, reg_idx_full;
  logic          lk_in, reg_in, wr_go;
  assign lk_idx_full  = lk_addr >> cur_shift;
  assign lk_in        = lk_idx_full < AW'(cur_count);
  assign reg_base     = (reg_addr & pmask_a) - cur_off;
  assign reg_idx_full = reg_base >> cur_shift;
  assign reg_in       = reg_idx_full < AW'(cur_count);
  assign wr_go        = reg_req && reg_we && reg_in;

  logic [IW-1:0] lk_idx, reg_idx;
  assign lk_idx  = lk_idx_full[IW-1:0];
  assign reg_idx = reg_idx_full[IW-1:0];

  // storage
  logic [EW-1:0] ram_a, ram_b;
  logic          vb_a, vb_b;

  dpt_ram #(.DW(EW), .DEPTH(DEPTH), .IW(IW)) u_ram (
    .clk(clk),
    .a_en(lk_req), .a_addr(lk_idx), .a_q(ram_a),
    .b_en(reg_req && reg_in), .b_we(wr_go), .b_addr(reg_idx), .b_wd(reg_wdata), .b_q(ram_b)
  );

  dpt_vbits #(.DEPTH(DEPTH), .IW(IW)) u_vbits (
    .clk(clk), .rst(rst), .wipe(wipe),
    .set_en(wr_go), .set_idx(reg_idx),
    .a_idx(lk_idx), .a_q(vb_a),
    .b_idx(reg_idx), .b_q(vb_b)
  );

  // lookup stage
  logic          lk_v_q, lk_in_q, lk_byp_q;
  logic [AW-1:0] lk_iova_q, pm_a_q;
  logic [EW-1:0] lk_bd_q, pm_e_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_v_q    <= 1'b0;
      lk_in_q   <= 1'b0;
      lk_byp_q  <= 1'b0;
      lk_iova_q <= '0;
      lk_bd_q   <= '0;
      pm_a_q    <= '0;
      pm_e_q    <= '0;
    end else begin
      lk_v_q    <= lk_req;
      lk_in_q   <= lk_req && lk_in;
      lk_byp_q  <= lk_req && lk_in && wr_go && (reg_idx == lk_idx);
      lk_iova_q <= lk_addr & pmask_a;
      lk_bd_q   <= reg_wdata;
      pm_a_q    <= pmask_a;
      pm_e_q    <= pmask_e;
    end
  end

  logic [EW-1:0] lk_entry;
  always_comb begin
    if (lk_byp_q)  lk_entry = lk_bd_q;
    else if (vb_a) lk_entry = ram_a;
    else           lk_entry = '0;
  end

  assign lk_valid = lk_v_q;
  assign lk_iova  = lk_in_q ? lk_iova_q : '0;
  assign lk_xlat  = lk_in_q ? (lk_entry & pm_e_q) : '0;
  assign lk_mask  = lk_in_q ? ~pm_a_q : '1;
  assign lk_perm  = lk_in_q ? lk_entry[PERM_W-1:0] : PERM_NONE;

  // register port stage and invalidate notice
  logic ack_q, err_q, rd_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q     <= 1'b0;
      err_q     <= 1'b0;
      rd_q      <= 1'b0;
      inv_valid <= 1'b0;
      inv_iova  <= '0;
      inv_xlat  <= '0;
      inv_perm  <= PERM_NONE;
    end else begin
      ack_q     <= reg_req;
      err_q     <= reg_req && !reg_in;
      rd_q      <= reg_req && !reg_we && reg_in;
      inv_valid <= wr_go;
      inv_iova  <= reg_base & pmask_a;
      inv_xlat  <= reg_wdata & pmask_e;
      inv_perm  <= reg_wdata[PERM_W-1:0];
    end
  end

  assign reg_ack   = ack_q;
  assign reg_err   = err_q;
  assign reg_rdata = (rd_q && vb_b) ? ram_b : '0;
endmodule

// File: rtl/dpt_xlate_table_chk.sv
module dpt_xlate_table_chk #(
  parameter int AW    = 48,
  parameter int EW    = 64,
  parameter int DEPTH = 256,
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_req,
  input logic             lk_valid,
  input logic [1:0]       lk_perm,
  input logic [AW-1:0]    lk_mask,
  input logic [EW-1:0]    lk_xlat,
  input logic             reg_req,
  input logic             reg_we,
  input logic             reg_ack,
  input logic             reg_err,
  input logic             inv_valid,
  input logic             cfg_disable,
  input logic [CNT_W-1:0] cur_count
);
  AST_LOOKUP_STROBE: assert property (@(posedge clk) disable iff (rst) lk_req |=> lk_valid); // R2
  AST_LOOKUP_IDLE: assert property (@(posedge clk) disable iff (rst) !lk_req |=> !lk_valid); // R2
  AST_CLOSED_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && $past(cur_count) == '0) |-> (lk_perm == 2'd0 && lk_mask == '1 && lk_xlat == '0)); // R5
  AST_REG_ACK: assert property (@(posedge clk) disable iff (rst) reg_req |=> reg_ack); // R6
  AST_ERR_NO_NOTICE: assert property (@(posedge clk) disable iff (rst) (reg_ack && reg_err) |-> !inv_valid); // R7
  AST_NOTICE_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    inv_valid |-> (reg_ack && !reg_err && $past(reg_req && reg_we))); // R8
  AST_OPEN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (cur_count != '0 && !cfg_disable) |=> $stable(cur_count)); // R10
  AST_CLOSE_CLEARS: assert property (@(posedge clk) disable iff (rst) cfg_disable |=> cur_count == '0); // R10
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst) cur_count <= CNT_W'(DEPTH)); // R11
endmodule

bind dpt_xlate_table dpt_xlate_table_chk #(.AW(AW), .EW(EW), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .lk_req(lk_req), .lk_valid(lk_valid), .lk_perm(lk_perm),
  .lk_mask(lk_mask), .lk_xlat(lk_xlat), .reg_req(reg_req), .reg_we(reg_we),
  .reg_ack(reg_ack), .reg_err(reg_err), .inv_valid(inv_valid),
  .cfg_disable(cfg_disable), .cur_count(cur_count)
);

// File: tb/test_dpt_xlate_table.sv
module test_dpt_xlate_table;
  localparam int AW = 48, EW = 64, SHW = 6, DEPTH = 256, CNT_W = 9;
  localparam logic [AW-1:0] ONES = '1;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_enable = 0, cfg_disable = 0;
  logic [SHW-1:0] cfg_page_shift = '0;
  logic [AW-1:0] cfg_bus_offset = '0;
  logic [CNT_W-1:0] cfg_entries = '0;
  logic lk_req = 0;
  logic [AW-1:0] lk_addr = '0;
  logic lk_valid;
  logic [AW-1:0] lk_iova, lk_mask;
  logic [EW-1:0] lk_xlat;
  logic [1:0] lk_perm;
  logic reg_req = 0, reg_we = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [EW-1:0] reg_wdata = '0;
  logic reg_ack, reg_err, inv_valid;
  logic [EW-1:0] reg_rdata, inv_xlat;
  logic [AW-1:0] inv_iova;
  logic [1:0] inv_perm;

  int n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  dpt_xlate_table #(.AW(AW), .EW(EW), .SHW(SHW), .DEPTH(DEPTH)) i_dpt_xlate_table (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_disable(cfg_disable),
    .cfg_page_shift(cfg_page_shift), .cfg_bus_offset(cfg_bus_offset), .cfg_entries(cfg_entries),
    .lk_req(lk_req), .lk_addr(lk_addr), .lk_valid(lk_valid), .lk_iova(lk_iova),
    .lk_xlat(lk_xlat), .lk_mask(lk_mask), .lk_perm(lk_perm),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_ack(reg_ack), .reg_err(reg_err), .reg_rdata(reg_rdata),
    .inv_valid(inv_valid), .inv_iova(inv_iova), .inv_xlat(inv_xlat), .inv_perm(inv_perm)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic do_enable(input logic [SHW-1:0] sh, input logic [AW-1:0] off, input logic [CNT_W-1:0] n);
    @(negedge clk);
    cfg_enable = 1; cfg_page_shift = sh; cfg_bus_offset = off; cfg_entries = n;
    @(negedge clk); cfg_enable = 0;
  endtask

  task automatic do_disable();
    @(negedge clk); cfg_disable = 1;
    @(negedge clk); cfg_disable = 0;
  endtask

  task automatic do_write(input string tag, input logic [AW-1:0] a, input logic [EW-1:0] d,
                          input logic exp_err, input logic [AW-1:0] exp_iova, input logic [EW-1:0] exp_xlat);
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_req = 0; reg_we = 0;
    chk({tag, " ack"}, 64'(reg_ack), 64'd1);
    chk({tag, " err"}, 64'(reg_err), 64'(exp_err));
    chk({tag, " inv_valid"}, 64'(inv_valid), 64'(!exp_err));
    if (!exp_err) begin
      chk({tag, " inv_iova"}, 64'(inv_iova), 64'(exp_iova));
      chk({tag, " inv_xlat"}, inv_xlat, exp_xlat);
      chk({tag, " inv_perm"}, 64'(inv_perm), 64'(d[1:0]));
    end
  endtask

  task automatic do_read(input string tag, input logic [AW-1:0] a, input logic exp_err, input logic [EW-1:0] exp_d);
    @(negedge clk);
    reg_req = 1; reg_we = 0; reg_addr = a;
    @(negedge clk);
    reg_req = 0;
    chk({tag, " ack"}, 64'(reg_ack), 64'd1);
    chk({tag, " err"}, 64'(reg_err), 64'(exp_err));
    chk({tag, " rdata"}, reg_rdata, exp_d);
  endtask

  task automatic do_lookup(input string tag, input logic [AW-1:0] a, input logic [1:0] ep,
                           input logic [AW-1:0] eiova, input logic [EW-1:0] exlat, input logic [AW-1:0] emask);
    @(negedge clk);
    lk_req = 1; lk_addr = a;
    @(negedge clk);
    lk_req = 0;
    chk({tag, " valid"}, 64'(lk_valid), 64'd1);
    chk({tag, " perm"}, 64'(lk_perm), 64'(ep));
    chk({tag, " iova"}, 64'(lk_iova), 64'(eiova));
    chk({tag, " xlat"}, lk_xlat, exlat);
    chk({tag, " mask"}, 64'(lk_mask), 64'(emask));
  endtask

  // R1: state right after reset and zeroed entries
  task automatic t_reset_state();
    do_reset();
    @(negedge clk);
    chk("R1 lk_valid after reset", 64'(lk_valid), 64'd0);
    chk("R1 reg_ack after reset", 64'(reg_ack), 64'd0);
    chk("R1 inv_valid after reset", 64'(inv_valid), 64'd0);
    do_lookup("R5 disabled after reset", 48'h3000, 2'd0, '0, '0, ONES);
    do_enable(6'd12, '0, 9'd16);
    do_read("R1 read zero", 48'h3000, 1'b0, '0);
    do_lookup("R1 lookup zero", 48'h3456, 2'd0, 48'h3000, '0, 48'hFFF);
  endtask

  // R2: strobe timing
  task automatic t_latency();
    @(negedge clk); lk_req = 1; lk_addr = 48'h1000;
    @(negedge clk); lk_req = 0;
    chk("R2 valid one cycle later", 64'(lk_valid), 64'd1);
    @(negedge clk);
    chk("R2 valid drops", 64'(lk_valid), 64'd0);
  endtask

  // R3 R4 R6 R8: each access code through write, lookup and read
  task automatic t_perm_codes();
    for (int p = 0; p < 4; p++) begin
      logic [EW-1:0] d;
      logic [AW-1:0] base;
      d = 64'h0000_0123_4567_80C0 | 64'(p);
      base = AW'(p + 1) << 12;
      do_write("R8 write", base + 48'h10, d, 1'b0, base, 64'h0000_0123_4567_8000);
      do_lookup("R3 R4 lookup", base + 48'hABC, 2'(p), base, 64'h0000_0123_4567_8000, 48'hFFF);
      do_read("R6 read", base, 1'b0, d);
    end
  endtask

  // R5 R7: outside the window
  task automatic t_out_of_range();
    do_lookup("R5 index at count", 48'h10000, 2'd0, '0, '0, ONES);
    do_write("R7 write beyond", 48'h10000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, '0, '0);
    do_read("R7 read beyond", 48'h10000, 1'b1, '0);
    do_lookup("R7 last entry untouched", 48'hF000, 2'd0, 48'hF000, '0, 48'hFFF);
    do_read("R7 entry 1 unchanged", 48'h2000, 1'b0, 64'h0000_0123_4567_80C1);
  endtask

  // R6 R7 R4: bus offset and larger page
  task automatic t_offset();
    do_disable();
    do_enable(6'd13, 48'h10000, 9'd8);
    do_write("R6 R8 offset write", 48'h14055, 64'hFEDC_BA98_7654_3213, 1'b0, 48'h4000, 64'hFEDC_BA98_7654_2000);
    do_read("R6 offset read", 48'h14000, 1'b0, 64'hFEDC_BA98_7654_3213);
    do_lookup("R4 no offset in lookup", 48'h4007, 2'd3, 48'h4000, 64'hFEDC_BA98_7654_2000, 48'h1FFF);
    do_write("R7 below offset", 48'h8000, 64'h5, 1'b1, '0, '0);
    do_write("R7 past window", 48'h20000, 64'h5, 1'b1, '0, '0);
  endtask

  // R9: write and lookup on one index in one cycle
  task automatic t_bypass();
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_addr = 48'h16000; reg_wdata = 64'h0000_00AA_BBCC_0001;
    lk_req = 1; lk_addr = 48'h6000;
    @(negedge clk);
    reg_req = 0; reg_we = 0; lk_req = 0;
    chk("R9 bypass perm", 64'(lk_perm), 64'd1);
    chk("R9 bypass xlat", lk_xlat, 64'h0000_00AA_BBCC_0000);
    chk("R9 notice", 64'(inv_valid), 64'd1);
  endtask

  // R10: enable while open, disable, simultaneous requests
  task automatic t_enable_rules();
    do_enable(6'd12, '0, 9'd4);
    do_lookup("R10 second enable ignored", 48'h4007, 2'd3, 48'h4000, 64'hFEDC_BA98_7654_2000, 48'h1FFF);
    @(negedge clk);
    cfg_disable = 1; cfg_enable = 1; cfg_page_shift = 6'd12; cfg_bus_offset = '0; cfg_entries = 9'd16;
    @(negedge clk);
    cfg_disable = 0; cfg_enable = 0;
    do_lookup("R10 disable wins", 48'h0, 2'd0, '0, '0, ONES);
    do_read("R10 closed read", 48'h10000, 1'b1, '0);
  endtask

  // R11: clamp and fresh table
  task automatic t_reenable();
    do_enable(6'd12, '0, 9'h1FF);
    do_lookup("R11 last clamped entry", 48'hFF123, 2'd0, 48'hFF000, '0, 48'hFFF);
    do_lookup("R11 clamp limit", 48'h100000, 2'd0, '0, '0, ONES);
    do_read("R11 old entry wiped", 48'h2000, 1'b0, '0);
    do_read("R11 bypass entry wiped", 48'h3000, 1'b0, '0);
  endtask

  // R1: reset in the middle of use
  task automatic t_reset_mid();
    do_write("R8 pre-reset write", 48'h5000, 64'h0000_0000_0009_9003, 1'b0, 48'h5000, 64'h0000_0000_0009_9000);
    do_lookup("R3 pre-reset lookup", 48'h5000, 2'd3, 48'h5000, 64'h0000_0000_0009_9000, 48'hFFF);
    do_reset();
    do_lookup("R1 R5 closed after reset", 48'h5000, 2'd0, '0, '0, ONES);
    do_enable(6'd12, '0, 9'd16);
    do_read("R1 entry cleared", 48'h5000, 1'b0, '0);
    do_lookup("R1 lookup cleared", 48'h5000, 2'd0, 48'h5000, '0, 48'hFFF);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    t_reset_state();
    t_latency();
    t_perm_codes();
    t_out_of_range();
    t_offset();
    t_bypass();
    t_enable_rules();
    t_reenable();
    t_reset_mid();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule